// File: doc/BRIEF.md
# Panel Command Word Serializer

This block takes packed 32-bit display-panel command words from a valid/ready handshake and sends each one over a transmit-only synchronous serial link. The link has three outputs: serial clock, frame strobe and transmit data. The top two bits of every word state how many parameter bytes travel with the command. From that count the block builds a frame of 9-bit slots. Each slot opens with a flag bit: 0 marks the command byte and 1 marks a parameter byte. A word with no parameter or one parameter gives a short 18-bit frame. A word with two parameters gives a long 27-bit frame.

Only one word is in flight at a time. The block lowers its ready output from the cycle after a word is accepted until the last bit of that word's frame has left the shifter. When the frame length class of a new word differs from the class of the previous word, the link is reconfigured while idle. This inserts a fixed gap before the frame strobe rises. The first word after reset always counts as a change. A count field of 3 is not legal: the word is consumed, nothing is sent, and a sticky error flag is raised. A busy level and a one-cycle completion pulse let the sender pace its writes.

Top module: `panel_cmd_serializer`

## Requirements
- R1: `in_ready` is high exactly when the block is idle. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. No word is taken while busy.
- R2: When the count field `in_word[31:30]` is 0, the frame is 18 bits. It is a 0 flag, then `in_word[16:9]`, then nine zero bits.
- R3: When the count field is 1, the frame is 18 bits. It is a 0 flag, then `in_word[16:9]`, then a 1 flag, then `in_word[7:0]`.
- R4: When the count field is 2, the frame is 27 bits. It is a 0 flag, then `in_word[25:18]`, then a 1 flag, then `in_word[16:9]`, then a 1 flag, then `in_word[7:0]`.
- R5: Bits leave MSB first on `txd`. `txd` changes only when `sclk` falls. `txd` is 0 whenever `frm` is low.
- R6: `sclk` idles low. Each half period lasts `DIV_HALF` system cycles. The first rise comes `DIV_HALF` cycles after `frm` rises.
- R7: `frm` stays high for exactly 2·`DIV_HALF`·(frame bits) cycles.
- R8: When the length class (short or long) differs from the previous valid word, `RECFG_CYC` busy cycles with `frm` low come before the frame. The first word after reset also counts as a change. When the class is unchanged, `frm` rises the cycle after acceptance.
- R9: `busy` is high from the cycle after acceptance until the frame ends. `done` pulses for one cycle on the first idle cycle after a frame.
- R10: A word with count field 3 is consumed and sends nothing. `in_ready` stays high, and `err` is set from the next cycle and stays set until reset.
- R11: After reset, `sclk`, `frm`, `txd`, `busy`, `done` and `err` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 32 | Packed command word, count field in bits 31:30 |
| sclk | output | 1 | Serial clock, idle low |
| frm | output | 1 | Frame strobe, high while bits are shifted |
| txd | output | 1 | Serial transmit data |
| busy | output | 1 | A word is being handled |
| done | output | 1 | One-cycle pulse after a frame completes |
| err | output | 1 | Sticky flag for an illegal count field |

## Verification
The bench sends words with each legal count. This separates the three slot layouts: an empty second slot in a short frame, a flagged parameter, and a three-slot long frame. It uses payload bytes whose flag positions hold the opposite of the required flag, so any leak of word bits into flag slots shows up. The order of the words alternates between repeated classes (no gap) and class switches (gap inserted), so the reconfiguration rule is seen both ways. An illegal count word in the middle of the stream shows that the error flag sets without disturbing the link or the class history. Words held valid while busy show that nothing is taken early.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
   localparam int CMD_W     = 32;
   localparam int SLOT_W    = 9;
   localparam int BYTE_W    = SLOT_W - 1;
   localparam int SHORT_LEN = 2 * SLOT_W;
   localparam int LONG_LEN  = 3 * SLOT_W;
   localparam int LEN_W     = $clog2(LONG_LEN + 1);
   localparam int CNT_LSB   = CMD_W - 2;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_GAP   = 2'd1,
      ST_SHIFT = 2'd2
   } pcs_state_t;

   typedef struct packed {
      logic [LONG_LEN-1:0] bits;   // left-aligned frame
      logic [LEN_W-1:0]    len;
      logic                long_f;
      logic                bad;
   } pcs_frame_t;
endpackage

// File: rtl/pcs_frame_fmt.sv
module pcs_frame_fmt
   import pcs_pkg::*;
(
   input  logic [CMD_W-1:0] word,
   output pcs_frame_t       frame
);
   localparam int PAD = LONG_LEN - SHORT_LEN;

   logic [1:0]        cnt;
   logic [BYTE_W-1:0] byte_hi;
   logic [BYTE_W-1:0] byte_mid;
   logic [BYTE_W-1:0] byte_lo;
   logic              unused_bits;

   assign cnt      = word[CNT_LSB +: 2];
   assign byte_hi  = word[2*SLOT_W +: BYTE_W];
   assign byte_mid = word[SLOT_W +: BYTE_W];
   assign byte_lo  = word[0 +: BYTE_W];
   assign unused_bits = ^{word[CNT_LSB-1:LONG_LEN-1], word[2*SLOT_W-1], word[SLOT_W-1]};

   always_comb begin
      frame = '0;
      unique case (cnt)
         2'd0: begin
            frame.bits = {1'b0, byte_mid, {SLOT_W{1'b0}}, {PAD{1'b0}}};
            frame.len  = LEN_W'(SHORT_LEN);
         end
         2'd1: begin
            frame.bits = {1'b0, byte_mid, 1'b1, byte_lo, {PAD{1'b0}}};
            frame.len  = LEN_W'(SHORT_LEN);
         end
         2'd2: begin
            frame.bits   = {1'b0, byte_hi, 1'b1, byte_mid, 1'b1, byte_lo};
            frame.len    = LEN_W'(LONG_LEN);
            frame.long_f = 1'b1;
         end
         default: frame.bad = 1'b1;
      endcase
   end
endmodule

// File: rtl/pcs_clkdiv.sv
module pcs_clkdiv #(
   parameter int DIV_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   generate
      if (DIV_HALF == 1) begin : g_pass
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign tick = en;
      end else begin : g_count
         localparam int CNT_W = $clog2(DIV_HALF);
         localparam logic [CNT_W-1:0] TOP = CNT_W'(DIV_HALF - 1);
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n || !en)   cnt <= '0;
            else if (cnt == TOP) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
         end
         assign tick = en && (cnt == TOP);
      end
   endgenerate
endmodule

// File: rtl/pcs_shifter.sv
module pcs_shifter
   import pcs_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [LONG_LEN-1:0] load_bits,
   input  logic [LEN_W-1:0]    load_len,
   input  logic                run,
   input  logic                tick,
   output logic                sclk,
   output logic                txd,
   output logic                last
);
   logic [LONG_LEN-1:0] shreg;
   logic [LEN_W-1:0]    left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= '0;
         left  <= '0;
         sclk  <= 1'b0;
      end else if (load) begin
         shreg <= load_bits;
         left  <= load_len;
         sclk  <= 1'b0;
      end else if (run && tick) begin
         if (!sclk) begin
            sclk <= 1'b1;
         end else begin
            sclk  <= 1'b0;
            shreg <= {shreg[LONG_LEN-2:0], 1'b0};
            left  <= left - 1'b1;
         end
      end
   end

   assign txd  = shreg[LONG_LEN-1];
   assign last = run && tick && sclk && (left == LEN_W'(1));
endmodule

// File: rtl/panel_cmd_serializer.sv
module panel_cmd_serializer
   import pcs_pkg::*;
#(
   parameter int DIV_HALF  = 2,
   parameter int RECFG_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [CMD_W-1:0] in_word,
   output logic             sclk,
   output logic             frm,
   output logic             txd,
   output logic             busy,
   output logic             done,
   output logic             err
);
   localparam int GAP_W = (RECFG_CYC > 1) ? $clog2(RECFG_CYC) : 1;
   localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(RECFG_CYC - 1);

   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("DIV_HALF must be at least 1");
      end
      if (RECFG_CYC < 1) begin : g_bad_gap
         $error("RECFG_CYC must be at least 1");
      end
   endgenerate

   pcs_state_t       state;
   logic [GAP_W-1:0] gap_cnt;
   logic             have_cfg;
   logic             last_long;
   pcs_frame_t       frame;
   logic             accept;
   logic             load;
   logic             change;
   logic             run;
   logic             tick;
   logic             last;

   pcs_frame_fmt u_fmt (
      .word  (in_word),
      .frame (frame)
   );

   assign in_ready = (state == ST_IDLE);
   assign accept   = in_valid && in_ready;
   assign load     = accept && !frame.bad;
   assign change   = !have_cfg || (frame.long_f != last_long);
   assign run      = (state == ST_SHIFT);

   pcs_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (run),
      .tick  (tick)
   );

   pcs_shifter u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_bits (frame.bits),
      .load_len  (frame.len),
      .run       (run),
      .tick      (tick),
      .sclk      (sclk),
      .txd       (txd),
      .last      (last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         gap_cnt   <= '0;
         have_cfg  <= 1'b0;
         last_long <= 1'b0;
         err       <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= last;
         unique case (state)
            ST_IDLE: begin
               if (accept && frame.bad) begin
                  err <= 1'b1;
               end else if (load) begin
                  have_cfg  <= 1'b1;
                  last_long <= frame.long_f;
                  if (change) begin
                     state   <= ST_GAP;
                     gap_cnt <= GAP_LOAD;
                  end else begin
                     state <= ST_SHIFT;
                  end
               end
            end
            ST_GAP: begin
               if (gap_cnt == '0) state <= ST_SHIFT;
               else               gap_cnt <= gap_cnt - 1'b1;
            end
            ST_SHIFT: begin
               if (last) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign frm  = run;
   assign busy = (state != ST_IDLE);
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_ready,
   input logic [1:0] cnt,
   input logic       sclk,
   input logic       frm,
   input logic       txd,
   input logic       busy,
   input logic       done,
   input logic       err
);
   p_ready_not_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !in_ready);

   p_txd_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(txd));

   p_txd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !frm |-> !txd);

   p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !frm |-> !sclk);

   p_strobe_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frm |-> busy);

   p_done_after_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frm) |-> done);

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && cnt == 2'b11) |=> err);

   p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
endmodule

bind panel_cmd_serializer pcs_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .cnt      (in_word[31:30]),
   .sclk     (sclk),
   .frm      (frm),
   .txd      (txd),
   .busy     (busy),
   .done     (done),
   .err      (err)
);

// File: tb/panel_cmd_serializer_tb.sv
module panel_cmd_serializer_tb;
   localparam int DIV_HALF  = 2;
   localparam int RECFG_CYC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_word = '0;
   logic        in_ready, sclk, frm, txd, busy, done, err;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit running = 1'b0;
   bit finished = 1'b0;

   // expected cycle entries: b0 frm, b1 sclk, b2 txd, b3 last, b4 busy, b11:8 tag
   int exp_q[$];
   int last_class = -1;
   bit exp_done = 1'b0;
   bit exp_err = 1'b0;

   always #4 clk = ~clk;

   panel_cmd_serializer #(.DIV_HALF(DIV_HALF), .RECFG_CYC(RECFG_CYC)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .sclk(sclk), .frm(frm), .txd(txd), .busy(busy),
      .done(done), .err(err)
   );

   function automatic string ttag(int t);
      case (t)
         2: return "R2";
         3: return "R3";
         4: return "R4";
         8: return "R8";
         default: return "R5";
      endcase
   endfunction

   task automatic chk(input bit got, input bit expv, input string req, input string what);
      checks++;
      if (got !== expv) begin
         errors++;
         $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", req, what, cycles, got, expv);
      end
   endtask

   function automatic int ent(bit f, bit s, bit d, bit l, bit b, int tag);
      return int'(f) | (int'(s) << 1) | (int'(d) << 2) | (int'(l) << 3) | (int'(b) << 4) | (tag << 8);
   endfunction

   // build the expected timeline of an accepted word from the requirements
   task automatic model_accept(input logic [31:0] w);
      int cnt = int'(w[31:30]);
      int cls;
      int tag;
      bit bits[$];
      if (cnt == 3) begin
         exp_err = 1'b1;                       // R10
         return;
      end
      cls = (cnt == 2) ? 1 : 0;
      tag = cnt + 2;                           // R2 / R3 / R4
      if (cls != last_class)
         for (int g = 0; g < RECFG_CYC; g++) exp_q.push_back(ent(0, 0, 0, 0, 1, 8));
      last_class = cls;
      bits.push_back(1'b0);
      if (cnt == 2) begin
         for (int i = 25; i >= 18; i--) bits.push_back(w[i]);
         bits.push_back(1'b1);
      end
      for (int i = 16; i >= 9; i--) bits.push_back(w[i]);
      if (cnt == 0) begin
         for (int i = 0; i < 9; i++) bits.push_back(1'b0);
      end else begin
         bits.push_back(1'b1);
         for (int i = 7; i >= 0; i--) bits.push_back(w[i]);
      end
      foreach (bits[k]) begin
         for (int h = 0; h < DIV_HALF; h++) exp_q.push_back(ent(1, 0, bits[k], 0, 1, tag));
         for (int h = 0; h < DIV_HALF; h++)
            exp_q.push_back(ent(1, 1, bits[k], (k == bits.size() - 1) && (h == DIV_HALF - 1), 1, tag));
      end
   endtask

   always @(posedge clk) if (running) cycles++;

   always @(negedge clk) begin
      if (running && !finished) begin
         int e;
         bit eb;
         e  = (exp_q.size() > 0) ? exp_q.pop_front() : ent(0, 0, 0, 0, 0, 5);
         eb = e[4];
         chk(frm,  e[0], (e[11:8] == 8) ? "R8" : "R7", "frm");
         chk(sclk, e[1], "R6", "sclk");
         chk(txd,  e[2], ttag(e[11:8]), "txd");
         chk(busy, eb, "R9", "busy");
         chk(in_ready, !eb, "R1", "in_ready");
         chk(done, exp_done, "R9", "done");
         chk(err,  exp_err, "R10", "err");
         exp_done = e[3];
         if (!eb && in_valid) model_accept(in_word);
      end
   end

   task automatic send(input logic [31:0] w);
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_word  = w;
      forever begin
         @(negedge clk);
         if (in_ready) break;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_word  = 32'h3FFF_FFFF;
   endtask

   task automatic drain();
      while (exp_q.size() > 0 || busy) @(posedge clk);
      repeat (3) @(posedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(sclk, 0, "R11", "reset sclk");
      chk(frm,  0, "R11", "reset frm");
      chk(txd,  0, "R11", "reset txd");
      chk(busy, 0, "R11", "reset busy");
      chk(done, 0, "R11", "reset done");
      chk(err,  0, "R11", "reset err");
      chk(in_ready, 1, "R11", "reset in_ready");
      running = 1'b1;
      // R2: no parameter, first word -> gap (R8)
      send((32'h29 << 9) | 32'h1FF);
      // R3: one parameter, same class -> no gap; flag positions hold opposite values
      send(32'h4000_0000 | (32'hB0 << 9) | 32'h016);
      send(32'h4000_0000 | (32'h55 << 9) | 32'h0AA);
      // R4: two parameters -> class change
      send(32'h8000_0000 | (32'hB8 << 18) | (32'hFF << 9) | 32'h0F9);
      send(32'h8000_0000 | (32'h3C << 18) | (32'h81 << 9) | 32'h07E);
      // R10: illegal count, class history untouched
      send(32'hC000_0000 | (32'h12 << 9) | 32'h034);
      send(32'h8000_0000 | (32'hD2 << 18) | (32'h14 << 9) | 32'h100);
      drain();
      // back to short after idle time
      send(32'h0000_0000 | (32'h11 << 9));
      send(32'h4000_0000 | 32'h0001FEFF);
      drain();
      send(32'hFFFF_FFFF);
      drain();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule